// File: doc/BRIEF.md
# I2C Byte-Write Memory Target

This block is an I2C target that fronts a 256-byte store modelled on a non-volatile memory. A controller selects it with a 7-bit target address. The upper bits of that address are a fixed parameter and the low three come from the `addr_sel` pins. The controller then sends an 8-bit word address and zero or more data bytes. Accepted data bytes go into a small page buffer. They reach the store only when a STOP condition closes the write, and even then only after a timed internal write cycle.

Reads return the byte at the current location and step the location forward, wrapping from the top of the store to the bottom. A read continues for as long as the controller acknowledges. The controller performs a random read by writing only a word address, issuing a repeated START, and then reading. The active-low `wc_n` input gates all writing. While `wc_n` is HIGH, data bytes are refused and the store cannot change. While the write cycle runs, `busy` is HIGH and the target does not answer its address.

The bus is sampled with the block clock through synchronisers, so SCL must be slow compared with `clk`. SDA is open-drain: `sda_oe` HIGH pulls the line low.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal {DEV_ID, addr_sel}, with DEV_ID defaulting to 4'b1010. Bit 0 is R/W, where 1 means read. Any other address byte is left unacknowledged, and the target then stays silent until the next START.
- R2: After a write address is accepted, the target acknowledges the word-address byte and each accepted data byte by holding SDA low during the ninth SCL pulse.
- R3: `sda_oe` changes only in the cycle after a detected SCL falling edge, START or STOP. It is low whenever no acknowledge or read bit is being driven.
- R4: A STOP that directly follows at least one accepted data byte raises `busy`. A STOP after only a word address does not raise `busy`, and neither does a repeated START after data followed by a read. In both of those cases the buffered bytes are dropped.
- R5: Once raised, `busy` stays HIGH for exactly WRITE_CYCLES clock cycles. The buffered bytes are in the store when it falls.
- R6: While `busy` is HIGH, a correctly addressed address byte is not acknowledged.
- R7: A word-address write followed by a repeated START and a read returns the byte stored at that word address.
- R8: Consecutive data bytes fill a 4-byte page. The low two address bits advance and wrap inside the page while the upper six bits stay fixed, so a later byte overwrites an earlier one in the same slot. Locations outside the page keep their contents.
- R9: While `wc_n` is HIGH, data bytes are not acknowledged, a STOP does not raise `busy`, and the store keeps its contents.
- R10: Each byte sent in a read comes from the current address, which then advances by one and wraps from 255 to 0. The read continues while the controller acknowledges. A read with no word address continues from where the last access left off.
- R11: After reset, `busy` is LOW, `sda_oe` is LOW and every store location reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | When HIGH, pull the data line low |
| addr_sel | input | SEL_W (3) | Low bits of the target address |
| wc_n | input | 1 | Write control; LOW allows writing, HIGH protects the store |
| busy | output | 1 | HIGH while the internal write cycle runs |

## Verification
The write path is driven with three patterns. A single byte tells the basic commit apart from no commit. Six bytes starting mid-page tell in-page wrap and slot overwrite apart from a linear write that would spill into the next page. A write ending with a repeated START instead of a STOP tells commit-on-STOP apart from commit-on-byte. Reads are tried as random reads, as sequential runs across the top of the store, and as current-address reads after an address-only write, which together separate pointer wrap from pointer reload. Protected writes and a transaction sent while the write cycle runs confirm that refusal leaves `busy` and the stored bytes untouched.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_DEV,
      PH_WORD,
      PH_WDATA,
      PH_RDATA,
      PH_DROP
   } phase_e;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/i2cm_bus_sync.sv
module i2cm_bus_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int N = SYNC_STAGES;

   logic [N-1:0] scl_pipe;
   logic [N-1:0] sda_pipe;
   logic         scl_q;
   logic         sda_q;
   logic         scl_s;

   generate
      if (N < 1) begin : g_bad_stages
         $error("SYNC_STAGES must be at least 1");
      end
      if (N == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe <= '1;
               sda_pipe <= '1;
            end else begin
               scl_pipe <= scl_i;
               sda_pipe <= sda_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe <= '1;
               sda_pipe <= '1;
            end else begin
               scl_pipe <= {scl_pipe[N-2:0], scl_i};
               sda_pipe <= {sda_pipe[N-2:0], sda_i};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_s     = scl_pipe[N-1];
   assign sda_s     = sda_pipe[N-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2cm_link.sv
module i2cm_link
   import i2cm_pkg::*;
#(
   parameter int          SEL_W  = 3,
   parameter logic [6-SEL_W:0] DEV_ID = 4'b1010,
   parameter int          ADDR_W = 8,
   parameter int          PW     = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                scl_rise,
   input  logic                scl_fall,
   input  logic                start_det,
   input  logic                stop_det,
   input  logic                sda_s,
   input  logic [SEL_W-1:0]    addr_sel,
   input  logic                wc_n,
   input  logic                busy,
   input  logic [BYTE_W-1:0]   rd_data,
   output logic                sda_oe,
   output logic [ADDR_W-1:0]   ptr,
   output logic                pg_load,
   output logic                byte_we,
   output logic [PW-1:0]       byte_slot,
   output logic [BYTE_W-1:0]   byte_data,
   output logic                commit_req
);
   phase_e             phase;
   logic               in_ack;
   logic [3:0]         bitcnt;
   logic [BYTE_W-1:0]  shreg;
   logic [BYTE_W-1:0]  tx;
   logic               rw;
   logic               mack;
   logic               armed;
   logic               addr_hit;

   assign addr_hit   = (shreg[7:1] == {DEV_ID, addr_sel});
   assign byte_data  = shreg;
   assign commit_req = stop_det & armed & ~wc_n & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         in_ack    <= 1'b0;
         bitcnt    <= '0;
         shreg     <= '0;
         tx        <= '0;
         rw        <= 1'b0;
         mack      <= 1'b0;
         armed     <= 1'b0;
         sda_oe    <= 1'b0;
         ptr       <= '0;
         pg_load   <= 1'b0;
         byte_we   <= 1'b0;
         byte_slot <= '0;
      end else begin
         pg_load <= 1'b0;
         byte_we <= 1'b0;
         if (start_det) begin
            phase  <= PH_DEV;
            in_ack <= 1'b0;
            bitcnt <= '0;
            sda_oe <= 1'b0;
            armed  <= 1'b0;
         end else if (stop_det) begin
            phase  <= PH_IDLE;
            in_ack <= 1'b0;
            sda_oe <= 1'b0;
            armed  <= 1'b0;
         end else begin
            unique case (phase)
               PH_DEV, PH_WORD, PH_WDATA: begin
                  if (!in_ack) begin
                     if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                     end else if (scl_fall && bitcnt == 4'd8) begin
                        bitcnt <= '0;
                        if (phase == PH_DEV) begin
                           rw <= shreg[0];
                           if (addr_hit && !busy) begin
                              in_ack <= 1'b1;
                              sda_oe <= 1'b1;
                           end else begin
                              phase <= PH_DROP;
                           end
                        end else if (phase == PH_WORD) begin
                           in_ack  <= 1'b1;
                           sda_oe  <= 1'b1;
                           ptr     <= shreg[ADDR_W-1:0];
                           pg_load <= 1'b1;
                        end else begin
                           if (!wc_n) begin
                              in_ack    <= 1'b1;
                              sda_oe    <= 1'b1;
                              byte_we   <= 1'b1;
                              byte_slot <= ptr[PW-1:0];
                              ptr       <= {ptr[ADDR_W-1:PW], ptr[PW-1:0] + PW'(1)};
                              armed     <= 1'b1;
                           end else begin
                              phase <= PH_DROP;
                           end
                        end
                     end
                  end else if (scl_fall) begin
                     in_ack <= 1'b0;
                     sda_oe <= 1'b0;
                     if (phase == PH_DEV) begin
                        if (rw) begin
                           phase  <= PH_RDATA;
                           tx     <= rd_data;
                           sda_oe <= ~rd_data[7];
                           ptr    <= ptr + ADDR_W'(1);
                        end else begin
                           phase <= PH_WORD;
                        end
                     end else begin
                        phase <= PH_WDATA;
                     end
                  end
               end
               PH_RDATA: begin
                  if (!in_ack) begin
                     if (scl_rise) begin
                        bitcnt <= bitcnt + 4'd1;
                     end else if (scl_fall) begin
                        if (bitcnt == 4'd8) begin
                           bitcnt <= '0;
                           sda_oe <= 1'b0;
                           in_ack <= 1'b1;
                        end else begin
                           sda_oe <= ~tx[6];
                           tx     <= {tx[6:0], 1'b0};
                        end
                     end
                  end else begin
                     if (scl_rise) begin
                        mack <= ~sda_s;
                     end else if (scl_fall) begin
                        in_ack <= 1'b0;
                        if (mack) begin
                           tx     <= rd_data;
                           sda_oe <= ~rd_data[7];
                           ptr    <= ptr + ADDR_W'(1);
                        end else begin
                           phase <= PH_DROP;
                        end
                     end
                  end
               end
               default: begin
                  sda_oe <= 1'b0;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/i2cm_store.sv
module i2cm_store
   import i2cm_pkg::*;
#(
   parameter int          DEPTH        = 256,
   parameter int          PAGE_BYTES   = 4,
   parameter int          WRITE_CYCLES = 5000,
   parameter logic [7:0]  ERASED       = 8'hFF,
   localparam int         ADDR_W       = $clog2(DEPTH),
   localparam int         PW           = $clog2(PAGE_BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wc_n,
   input  logic [ADDR_W-1:0]  ptr,
   input  logic               pg_load,
   input  logic               byte_we,
   input  logic [PW-1:0]      byte_slot,
   input  logic [BYTE_W-1:0]  byte_data,
   input  logic               commit_req,
   output logic [BYTE_W-1:0]  rd_data,
   output logic               busy,
   output logic               mem_we
);
   localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

   logic [BYTE_W-1:0]      mem  [DEPTH];
   logic [BYTE_W-1:0]      pbuf [PAGE_BYTES];
   logic [PAGE_BYTES-1:0]  pvalid;
   logic [ADDR_W-PW-1:0]   base;
   logic [CNT_W-1:0]       cnt;

   generate
      if (WRITE_CYCLES < 1) begin : g_bad_cycles
         $error("WRITE_CYCLES must be at least 1");
      end
   endgenerate

   assign busy    = (cnt != '0);
   assign mem_we  = (cnt == CNT_W'(1)) & ~wc_n;
   assign rd_data = mem[ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         base   <= '0;
         pvalid <= '0;
         for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
         for (int j = 0; j < DEPTH; j++) mem[j] <= ERASED;
      end else begin
         if (pg_load) begin
            pvalid <= '0;
            base   <= ptr[ADDR_W-1:PW];
         end else if (byte_we) begin
            pbuf[byte_slot]   <= byte_data;
            pvalid[byte_slot] <= 1'b1;
         end
         if (commit_req) begin
            cnt <= CNT_W'(WRITE_CYCLES);
         end else if (busy) begin
            cnt <= cnt - CNT_W'(1);
         end
         if (mem_we) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
               if (pvalid[i]) mem[{base, PW'(i)}] <= pbuf[i];
            end
         end
      end
   end

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
   import i2cm_pkg::*;
#(
   parameter int               SEL_W        = 3,
   parameter logic [6-SEL_W:0] DEV_ID       = 4'b1010,
   parameter int               DEPTH        = 256,
   parameter int               PAGE_BYTES   = 4,
   parameter int               WRITE_CYCLES = 5000,
   parameter int               SYNC_STAGES  = 2,
   parameter logic [7:0]       ERASED       = 8'hFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   input  logic [SEL_W-1:0] addr_sel,
   input  logic             wc_n,
   output logic             busy
);
   localparam int ADDR_W = $clog2(DEPTH);
   localparam int PW     = $clog2(PAGE_BYTES);

   generate
      if (DEPTH > 256 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two no larger than 256");
      end
      if (PAGE_BYTES < 2 || (1 << PW) != PAGE_BYTES || PAGE_BYTES * 2 > DEPTH) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two, at least 2, at most DEPTH/2");
      end
      if (SEL_W < 1 || SEL_W > 6) begin : g_bad_sel
         $error("SEL_W out of range");
      end
   endgenerate

   logic               sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [ADDR_W-1:0]  ptr;
   logic               pg_load, byte_we, commit_req, mem_we;
   logic [PW-1:0]      byte_slot;
   logic [BYTE_W-1:0]  byte_data, rd_data;

   i2cm_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   i2cm_link #(.SEL_W(SEL_W), .DEV_ID(DEV_ID), .ADDR_W(ADDR_W), .PW(PW)) u_link (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
      .addr_sel(addr_sel), .wc_n(wc_n), .busy(busy), .rd_data(rd_data),
      .sda_oe(sda_oe), .ptr(ptr), .pg_load(pg_load), .byte_we(byte_we),
      .byte_slot(byte_slot), .byte_data(byte_data), .commit_req(commit_req)
   );

   i2cm_store #(.DEPTH(DEPTH), .PAGE_BYTES(PAGE_BYTES),
                .WRITE_CYCLES(WRITE_CYCLES), .ERASED(ERASED)) u_store (
      .clk(clk), .rst_n(rst_n), .wc_n(wc_n), .ptr(ptr), .pg_load(pg_load),
      .byte_we(byte_we), .byte_slot(byte_slot), .byte_data(byte_data),
      .commit_req(commit_req), .rd_data(rd_data), .busy(busy), .mem_we(mem_we)
   );

endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker #(
   parameter int WRITE_CYCLES = 5000
) (
   input logic clk,
   input logic rst_n,
   input logic wc_n,
   input logic busy,
   input logic sda_oe,
   input logic mem_we,
   input logic commit_req,
   input logic scl_fall,
   input logic start_det,
   input logic stop_det
);
   int unsigned busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_len <= 0;
      else if (busy) busy_len <= busy_len + 1;
      else busy_len <= 0;
   end

   // R9: protected store never written
   assert_wc_protect_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wc_n |-> !mem_we);

   // R4: a commit request starts the write cycle
   assert_busy_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      commit_req |=> busy);

   // R5: write cycle length
   assert_cycle_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_len == WRITE_CYCLES));

   // R5: store only written inside the write cycle
   assert_we_in_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);

   // R3: SDA drive moves only after a bus event
   assert_sda_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> $past(scl_fall | start_det | stop_det));

   // R3: a START or STOP always releases the line
   assert_sda_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det | stop_det) |=> !sda_oe);

endmodule

bind i2c_eeprom_target i2cm_checker #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .wc_n(wc_n), .busy(busy), .sda_oe(sda_oe),
   .mem_we(mem_we), .commit_req(commit_req), .scl_fall(scl_fall),
   .start_det(start_det), .stop_det(stop_det)
);

// File: tb/i2c_eeprom_target_tb.sv
module i2c_eeprom_target_tb;
   localparam int WCYC = 300;
   localparam int Q    = 10;
   localparam logic [7:0] DEV_W = 8'hAA;  // 1010 101 0
   localparam logic [7:0] DEV_R = 8'hAB;
   localparam logic [7:0] DEV_X = 8'hA8;  // wrong select bits

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic wc_n = 1'b0;
   logic sda_oe, busy;
   logic sda_line;
   logic [2:0] addr_sel = 3'b101;

   always #2.5 clk = ~clk;
   assign sda_line = m_sda & ~sda_oe;

   i2c_eeprom_target #(.WRITE_CYCLES(WCYC)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .sda_oe(sda_oe), .addr_sel(addr_sel), .wc_n(wc_n), .busy(busy)
   );

   int vectors = 0;
   int fails = 0;
   bit done = 0;
   logic [7:0] model [256];

   typedef struct { string tag; logic [7:0] val; } exp_t;
   exp_t exq[$];

   int busy_run = 0;
   int last_len = 0;
   always @(negedge clk) begin
      if (busy) busy_run++;
      else if (busy_run != 0) begin last_len = busy_run; busy_run = 0; end
   end

   task automatic tick(int n); repeat (n) @(negedge clk); endtask

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push(string tag, logic [7:0] v); exq.push_back('{tag, v}); endtask

   // monitor: compares each observed bus item with the scoreboard head
   task automatic observe(logic [7:0] act);
      exp_t e;
      vectors++;
      if (exq.size() == 0) begin
         fails++;
         $display("FAIL unexpected item actual=%0h expected=none", act);
      end else begin
         e = exq.pop_front();
         if (act !== e.val) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", e.tag, act, e.val);
         end
      end
   endtask

   task automatic i2c_start;
      m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
      m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
   endtask

   task automatic i2c_stop;
      m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q);
      m_sda = 1'b1; tick(Q);
   endtask

   task automatic send_bit(logic b);
      m_sda = b; tick(Q); m_scl = 1'b1; tick(Q); m_scl = 1'b0; tick(Q);
   endtask

   task automatic recv_bit(output logic b);
      m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q/2);
      b = sda_line; tick(Q/2); m_scl = 1'b0; tick(Q);
   endtask

   task automatic wbyte(logic [7:0] d);
      logic a;
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      recv_bit(a);
      observe({7'd0, a});
   endtask

   task automatic rbyte(logic ack);
      logic [7:0] v;
      for (int i = 7; i >= 0; i--) recv_bit(v[i]);
      send_bit(~ack);
      observe(v);
   endtask

   task automatic wait_idle;
      int n = 0;
      while (busy && n < 5 * WCYC) begin tick(1); n++; end
   endtask

   // page write with model update (in-page wrap)
   task automatic page_write(logic [7:0] a, int n, logic [7:0] first, string tag);
      logic [7:0] p = a;
      i2c_start;
      push(tag, 8'd0); wbyte(DEV_W);
      push(tag, 8'd0); wbyte(a);
      for (int i = 0; i < n; i++) begin
         push(tag, 8'd0); wbyte(first + 8'(i * 17));
         model[p] = first + 8'(i * 17);
         p = {p[7:2], p[1:0] + 2'd1};
      end
      i2c_stop;
   endtask

   task automatic random_read(logic [7:0] a, int n, string tag);
      logic [7:0] p = a;
      i2c_start;
      push(tag, 8'd0); wbyte(DEV_W);
      push(tag, 8'd0); wbyte(a);
      i2c_start;
      push(tag, 8'd0); wbyte(DEV_R);
      for (int i = 0; i < n; i++) begin
         push(tag, model[p]); rbyte(i != n - 1);
         p = p + 8'd1;
      end
      i2c_stop;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) model[i] = 8'hFF;
      tick(5); rst_n = 1'b1; tick(5);

      check("R11 busy after reset", 32'(busy), 0);
      check("R11 sda_oe after reset", 32'(sda_oe), 0);

      // R1: wrong target address is not acknowledged
      i2c_start; push("R1 wrong address nack", 8'd1); wbyte(DEV_X); i2c_stop;

      // R2, R4, R6, R5: byte write
      page_write(8'h10, 1, 8'hA5, "R2 byte write ack");
      check("R4 busy after stop", 32'(busy), 1);
      i2c_start; push("R6 nack while busy", 8'd1); wbyte(DEV_W); i2c_stop;
      wait_idle;
      check("R5 write cycle length", 32'(last_len), 32'(WCYC));

      // R7, R11: random read of written byte then erased neighbours
      random_read(8'h10, 3, "R7 random read");

      // R8: page wrap
      page_write(8'h22, 6, 8'h11, "R8 page write ack");
      wait_idle;
      random_read(8'h1E, 7, "R8 page contents");

      // R9: write protect
      wc_n = 1'b1;
      i2c_start;
      push("R9 addr ack", 8'd0); wbyte(DEV_W);
      push("R9 word ack", 8'd0); wbyte(8'h40);
      push("R9 data nack", 8'd1); wbyte(8'h77);
      i2c_stop;
      tick(4);
      check("R9 no busy when protected", 32'(busy), 0);
      wc_n = 1'b0;
      random_read(8'h40, 1, "R9 store unchanged");

      // R4: word-address only, then R10 current-address read
      i2c_start;
      push("R4 addr ack", 8'd0); wbyte(DEV_W);
      push("R4 word ack", 8'd0); wbyte(8'h12);
      i2c_stop;
      tick(4);
      check("R4 no busy after word-only write", 32'(busy), 0);
      i2c_start; push("R10 current addr ack", 8'd0); wbyte(DEV_R);
      push("R10 current read", model[8'h12]); rbyte(1'b0); i2c_stop;

      // R10: wrap from 255 to 0
      page_write(8'h00, 1, 8'h5A, "R10 setup");
      wait_idle;
      page_write(8'hFF, 1, 8'h3C, "R10 setup");
      wait_idle;
      random_read(8'hFF, 2, "R10 wrap read");
      i2c_start; push("R10 resume ack", 8'd0); wbyte(DEV_R);
      push("R10 resume read", model[8'h01]); rbyte(1'b0); i2c_stop;

      // R4: repeated START after data drops the write
      i2c_start;
      push("R4 rs addr", 8'd0); wbyte(DEV_W);
      push("R4 rs word", 8'd0); wbyte(8'h60);
      push("R4 rs data", 8'd0); wbyte(8'h99);
      i2c_start;
      push("R4 rs read addr", 8'd0); wbyte(DEV_R);
      push("R4 rs read", model[8'h61]); rbyte(1'b0);
      i2c_stop;
      tick(4);
      check("R4 no busy after repeated start", 32'(busy), 0);
      random_read(8'h60, 1, "R4 dropped data");

      check("scoreboard drained", 32'(exq.size()), 0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule